// File: doc/BRIEF.md
# Coprocessor Array Interface Controller

This block couples a scalar processor pipeline to an attached configurable compute array. The processor issues commands through one port. A configure command makes a named array configuration resident. Two move-to-array commands load the two operand registers. A move-from-array command returns the array's result. An execute command starts a multi-cycle array operation whose length in cycles comes from software.

The controller keeps a small fully associative store of configuration tags. A configure command completes in one cycle if its configuration is already selected or already cached. If the configuration is absent, the controller asks an external loader for it and holds the processor until the loader acknowledges. An execute command loads a cycle counter and pulses a start strobe toward the array. The processor stays frozen until the counter has run out. A command presented during a freeze is held and is accepted in the first cycle in which the freeze is gone.

Top module: `cpa_ctrl`

## Requirements
- R1: After reset, `stall`, `fetch_req`, `arr_start`, `rsp_valid` and `arr_cfg_live` are all 0.
- R2: A configure command (`cmd_op`=1) whose ID matches the currently selected configuration is accepted without stall, raises no `fetch_req`, and leaves `arr_cfg_slot` unchanged.
- R3: A configure command whose ID is in the cache but not selected completes in one cycle without `fetch_req`: the cycle after acceptance `arr_cfg_slot` shows its slot and `stall` is 0.
- R4: A configure command whose ID is absent raises `fetch_req` in the cycle after acceptance, with `fetch_id` equal to the ID and `fetch_slot` equal to the chosen slot. `stall` stays high until `fetch_done` is sampled high. In the cycle after that, the configuration is selected in that slot and `fetch_req` and `stall` are 0.
- R5: On a miss, the lowest-numbered empty slot is filled first. When no slot is empty, the least recently used slot is replaced; a hit or a fill counts as a use.
- R6: A move-to-array command writes `cmd_data` to `arr_opa` when `cmd_op`=2 and to `arr_opb` when `cmd_op`=3. The new value is visible the cycle after acceptance.
- R7: A move-from-array command (`cmd_op`=4) drives `rsp_valid` high for one cycle, the cycle after acceptance. In that cycle `rsp_data` holds `arr_result` as sampled at acceptance.
- R8: An execute command (`cmd_op`=5) pulses `arr_start` for exactly one cycle, the cycle after acceptance.
- R9: After an execute command with `cmd_cycles`=N is accepted, `stall` is high for exactly N cycles. When N=0 there is no stall.
- R10: A command presented while `stall` is high, including a move-from-array, is not accepted. It is accepted in the first cycle in which `stall` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Opcode: 0 none, 1 configure, 2 operand A, 3 operand B, 4 read result, 5 execute |
| cmd_cfg_id | input | ID_W | Configuration ID for configure |
| cmd_data | input | DATA_W | Operand data for move-to-array |
| cmd_cycles | input | CNT_W | Operation length for execute |
| rsp_data | output | DATA_W | Result returned to the processor |
| rsp_valid | output | 1 | Result strobe |
| stall | output | 1 | Processor freeze; commands are accepted only when low |
| arr_cfg_slot | output | SLOT_W | Cache slot of the selected configuration |
| arr_cfg_live | output | 1 | A configuration is selected |
| arr_opa | output | DATA_W | Operand A register |
| arr_opb | output | DATA_W | Operand B register |
| arr_result | input | DATA_W | Array result |
| arr_start | output | 1 | Execute start strobe |
| fetch_req | output | 1 | Configuration load request |
| fetch_id | output | ID_W | ID to load |
| fetch_slot | output | SLOT_W | Slot the loaded configuration goes into |
| fetch_done | input | 1 | Load acknowledgement |

## Verification
The bound checker watches several properties on every cycle. The start strobe and the result strobe must each follow an accepted command of the matching opcode. A load request must hold until it is acknowledged and must keep the processor frozen. A nonzero execute length must raise the freeze on the following cycle. Other behaviours need the bench's directed scenarios because they depend on exact values and on history: the full length of the freeze, the choice of replacement slot after a sequence of hits and fills, the difference between a selected hit and a cached hit, and a read that is held behind a running operation.

// File: rtl/cpa_pkg.sv
package cpa_pkg;
   typedef enum logic [2:0] {
      OP_NONE = 3'd0,
      OP_CFG  = 3'd1,
      OP_MTA  = 3'd2,
      OP_MTB  = 3'd3,
      OP_MFA  = 3'd4,
      OP_EXEC = 3'd5
   } cpa_op_e;

   typedef enum logic [0:0] {
      ST_IDLE  = 1'b0,
      ST_FETCH = 1'b1
   } cpa_state_e;
endpackage

// File: rtl/cpa_cycle_ctr.sv
module cpa_cycle_ctr #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             busy
);
   logic [CNT_W-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           remain <= '0;
      else if (load)        remain <= load_val;
      else if (remain != 0) remain <= remain - 1'b1;
   end

   assign busy = (remain != '0);
endmodule

// File: rtl/cpa_cfg_cache.sv
module cpa_cfg_cache #(
   parameter int ID_W    = 8,
   parameter int SLOTS   = 4,
   parameter bit USE_LRU = 1'b1,
   localparam int SLOT_W = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ID_W-1:0]   lk_id,
   output logic              hit,
   output logic [SLOT_W-1:0] hit_slot,
   output logic [SLOT_W-1:0] victim,
   input  logic              fill_en,
   input  logic [SLOT_W-1:0] fill_slot,
   input  logic [ID_W-1:0]   fill_id,
   input  logic              touch_en,
   input  logic [SLOT_W-1:0] touch_slot
);
   logic [ID_W-1:0] tag   [SLOTS];
   logic [SLOTS-1:0] valid;
   logic [SLOTS-1:0] match;

   for (genvar g = 0; g < SLOTS; g++) begin : g_entry
      assign match[g] = valid[g] && (tag[g] == lk_id);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid[g] <= 1'b0;
            tag[g]   <= '0;
         end else if (fill_en && fill_slot == SLOT_W'(g)) begin
            valid[g] <= 1'b1;
            tag[g]   <= fill_id;
         end
      end
   end

   always_comb begin
      hit      = |match;
      hit_slot = '0;
      for (int i = SLOTS - 1; i >= 0; i--)
         if (match[i]) hit_slot = SLOT_W'(i);
   end

   logic              have_empty;
   logic [SLOT_W-1:0] empty_slot;
   logic [SLOT_W-1:0] evict_slot;

   always_comb begin
      have_empty = 1'b0;
      empty_slot = '0;
      for (int i = SLOTS - 1; i >= 0; i--)
         if (!valid[i]) begin
            have_empty = 1'b1;
            empty_slot = SLOT_W'(i);
         end
   end

   if (USE_LRU) begin : g_lru
      logic [SLOT_W-1:0] age [SLOTS];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) age[i] <= SLOT_W'(i);
         end else if (touch_en) begin
            for (int i = 0; i < SLOTS; i++) begin
               if (touch_slot == SLOT_W'(i))    age[i] <= '0;
               else if (age[i] < age[touch_slot]) age[i] <= age[i] + 1'b1;
            end
         end
      end
      always_comb begin
         evict_slot = '0;
         for (int i = 0; i < SLOTS; i++)
            if (age[i] == SLOT_W'(SLOTS - 1)) evict_slot = SLOT_W'(i);
      end
   end else begin : g_rr
      logic [SLOT_W-1:0] ptr;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       ptr <= '0;
         else if (fill_en) ptr <= (ptr == SLOT_W'(SLOTS - 1)) ? '0 : ptr + 1'b1;
      end
      assign evict_slot = ptr;
   end

   assign victim = have_empty ? empty_slot : evict_slot;
endmodule

// File: rtl/cpa_ctrl.sv
module cpa_ctrl #(
   parameter int DATA_W  = 32,
   parameter int ID_W    = 8,
   parameter int CNT_W   = 16,
   parameter int SLOTS   = 4,
   parameter bit USE_LRU = 1'b1,
   localparam int SLOT_W = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [ID_W-1:0]   cmd_cfg_id,
   input  logic [DATA_W-1:0] cmd_data,
   input  logic [CNT_W-1:0]  cmd_cycles,
   output logic [DATA_W-1:0] rsp_data,
   output logic              rsp_valid,
   output logic              stall,
   output logic [SLOT_W-1:0] arr_cfg_slot,
   output logic              arr_cfg_live,
   output logic [DATA_W-1:0] arr_opa,
   output logic [DATA_W-1:0] arr_opb,
   input  logic [DATA_W-1:0] arr_result,
   output logic              arr_start,
   output logic              fetch_req,
   output logic [ID_W-1:0]   fetch_id,
   output logic [SLOT_W-1:0] fetch_slot,
   input  logic              fetch_done
);
   import cpa_pkg::*;

   if (SLOTS < 2 || (1 << SLOT_W) != SLOTS) begin : g_bad_slots
      $error("SLOTS must be a power of two of at least 2");
   end
   if (DATA_W < 1 || ID_W < 1 || CNT_W < 1) begin : g_bad_width
      $error("widths must be positive");
   end

   cpa_state_e        state;
   logic              accept, do_cfg, do_exec;
   logic              hit, ctr_busy;
   logic [SLOT_W-1:0] hit_slot, victim;
   logic              fill_en, touch_en;
   logic [SLOT_W-1:0] touch_slot;

   assign accept  = cmd_valid && !stall;
   assign do_cfg  = accept && cmd_op == OP_CFG;
   assign do_exec = accept && cmd_op == OP_EXEC;
   assign stall   = (state == ST_FETCH) || ctr_busy;
   assign fetch_req = (state == ST_FETCH);

   assign fill_en    = (state == ST_FETCH) && fetch_done;
   assign touch_en   = fill_en || (do_cfg && hit);
   assign touch_slot = fill_en ? fetch_slot : hit_slot;

   cpa_cfg_cache #(.ID_W(ID_W), .SLOTS(SLOTS), .USE_LRU(USE_LRU)) u_cache (
      .clk(clk), .rst_n(rst_n),
      .lk_id(cmd_cfg_id), .hit(hit), .hit_slot(hit_slot), .victim(victim),
      .fill_en(fill_en), .fill_slot(fetch_slot), .fill_id(fetch_id),
      .touch_en(touch_en), .touch_slot(touch_slot)
   );

   cpa_cycle_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk(clk), .rst_n(rst_n),
      .load(do_exec), .load_val(cmd_cycles), .busy(ctr_busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= ST_IDLE;
         fetch_id     <= '0;
         fetch_slot   <= '0;
         arr_cfg_slot <= '0;
         arr_cfg_live <= 1'b0;
      end else if (state == ST_FETCH) begin
         if (fetch_done) begin
            state        <= ST_IDLE;
            arr_cfg_slot <= fetch_slot;
            arr_cfg_live <= 1'b1;
         end
      end else if (do_cfg) begin
         if (hit) begin
            arr_cfg_slot <= hit_slot;
            arr_cfg_live <= 1'b1;
         end else begin
            state      <= ST_FETCH;
            fetch_id   <= cmd_cfg_id;
            fetch_slot <= victim;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arr_opa   <= '0;
         arr_opb   <= '0;
         rsp_data  <= '0;
         rsp_valid <= 1'b0;
         arr_start <= 1'b0;
      end else begin
         rsp_valid <= accept && cmd_op == OP_MFA;
         arr_start <= do_exec;
         if (accept && cmd_op == OP_MTA) arr_opa  <= cmd_data;
         if (accept && cmd_op == OP_MTB) arr_opb  <= cmd_data;
         if (accept && cmd_op == OP_MFA) rsp_data <= arr_result;
      end
   end
endmodule

module cpa_ctrl_chk #(
   parameter int ID_W   = 8,
   parameter int CNT_W  = 16,
   parameter int SLOT_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic [2:0]        cmd_op,
   input logic [CNT_W-1:0]  cmd_cycles,
   input logic              stall,
   input logic              rsp_valid,
   input logic              arr_start,
   input logic              fetch_req,
   input logic [ID_W-1:0]   fetch_id,
   input logic [SLOT_W-1:0] fetch_slot,
   input logic              fetch_done
);
   // R8
   start_after_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arr_start |-> $past(cmd_valid && !stall && cmd_op == 3'd5));

   // R7
   rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(cmd_valid && !stall && cmd_op == 3'd4));

   // R4
   fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && !fetch_done) |=> (fetch_req && $stable(fetch_id) && $stable(fetch_slot)));

   // R4
   fetch_freezes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req |-> stall);

   // R9
   exec_freezes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !stall && cmd_op == 3'd5 && cmd_cycles != '0) |=> stall);

   // R10
   start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_start && stall) |=> !arr_start);
endmodule

bind cpa_ctrl cpa_ctrl_chk #(.ID_W(ID_W), .CNT_W(CNT_W), .SLOT_W(SLOT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
   .cmd_cycles(cmd_cycles), .stall(stall), .rsp_valid(rsp_valid),
   .arr_start(arr_start), .fetch_req(fetch_req), .fetch_id(fetch_id),
   .fetch_slot(fetch_slot), .fetch_done(fetch_done)
);

// File: tb/cpa_ctrl_bench.sv
module cpa_ctrl_bench;
   localparam int DW = 32, IW = 8, CW = 16, SW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [2:0]    cmd_op = '0;
   logic [IW-1:0] cmd_cfg_id = '0;
   logic [DW-1:0] cmd_data = '0;
   logic [CW-1:0] cmd_cycles = '0;
   logic [DW-1:0] rsp_data, arr_opa, arr_opb, arr_result;
   logic          rsp_valid, stall, arr_cfg_live, arr_start, fetch_req;
   logic          fetch_done = 1'b0;
   logic [SW-1:0] arr_cfg_slot, fetch_slot;
   logic [IW-1:0] fetch_id;

   int  n_chk = 0, n_bad = 0;
   bit  finished = 0;

   always #4 clk = ~clk;

   assign arr_result = (arr_opa ^ 32'h5A5A_0000) + arr_opb;

   cpa_ctrl u_cpa_ctrl (.*);

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // caller sits at a negedge; returns at the negedge after acceptance
   task automatic send(input logic [2:0] op, input logic [IW-1:0] id,
                       input logic [DW-1:0] d, input logic [CW-1:0] cy, output int held);
      cmd_valid = 1'b1; cmd_op = op; cmd_cfg_id = id; cmd_data = d; cmd_cycles = cy;
      held = 0;
      while (stall) begin held++; @(negedge clk); end
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 3'd0;
   endtask

   task automatic cfg_miss(input logic [IW-1:0] id, input logic [SW-1:0] exp_slot, input int waits);
      int h;
      send(3'd1, id, '0, '0, h);
      chk(fetch_req == 1'b1, "R4 fetch_req", 32'(fetch_req), 1);
      chk(fetch_id == id, "R4 fetch_id", 32'(fetch_id), 32'(id));
      chk(fetch_slot == exp_slot, "R5 victim slot", 32'(fetch_slot), 32'(exp_slot));
      for (int i = 0; i < waits; i++) begin
         chk(stall == 1'b1, "R4 stall while loading", 32'(stall), 1);
         @(negedge clk);
      end
      fetch_done = 1'b1;
      @(negedge clk);
      fetch_done = 1'b0;
      chk(!stall && !fetch_req, "R4 load done", {stall, fetch_req}, 0);
      chk(arr_cfg_slot == exp_slot && arr_cfg_live, "R4 selected", 32'(arr_cfg_slot), 32'(exp_slot));
   endtask

   task automatic t_reset;
      chk(!stall && !fetch_req && !arr_start && !rsp_valid && !arr_cfg_live, "R1 reset outputs",
          {stall, fetch_req, arr_start, rsp_valid, arr_cfg_live}, 0);
   endtask

   task automatic t_fill_and_lru;
      int h;
      cfg_miss(8'd10, 2'd0, 2);
      cfg_miss(8'd11, 2'd1, 0);
      cfg_miss(8'd12, 2'd2, 1);
      cfg_miss(8'd13, 2'd3, 3);
      // R3 cached hit on id 10 (slot 0) while slot 3 selected
      send(3'd1, 8'd10, '0, '0, h);
      chk(arr_cfg_slot == 2'd0 && !stall && !fetch_req, "R3 cached hit", 32'(arr_cfg_slot), 0);
      // R2 hit on selected configuration
      send(3'd1, 8'd10, '0, '0, h);
      chk(h == 0 && !stall && !fetch_req && arr_cfg_slot == 2'd0, "R2 active hit",
          32'(arr_cfg_slot), 0);
      // R5 least recently used is slot 1 (id 11)
      cfg_miss(8'd14, 2'd1, 1);
      // id 11 evicted, LRU now slot 2
      cfg_miss(8'd11, 2'd2, 0);
   endtask

   task automatic t_moves;
      int h;
      send(3'd2, '0, 32'h0000_1234, '0, h);
      chk(arr_opa == 32'h0000_1234, "R6 operand A", arr_opa, 32'h1234);
      send(3'd3, '0, 32'h0000_0077, '0, h);
      chk(arr_opb == 32'h77 && arr_opa == 32'h1234, "R6 operand B", arr_opb, 32'h77);
      send(3'd4, '0, '0, '0, h);
      chk(rsp_valid && rsp_data == 32'h5A5A_12AB, "R7 read result", rsp_data, 32'h5A5A_12AB);
      @(negedge clk);
      chk(!rsp_valid, "R7 strobe one cycle", 32'(rsp_valid), 0);
   endtask

   task automatic t_exec;
      int h, cnt;
      send(3'd5, '0, '0, 16'd3, h);
      chk(arr_start == 1'b1, "R8 start pulse", 32'(arr_start), 1);
      cnt = 0;
      while (stall && cnt < 50) begin
         cnt++;
         @(negedge clk);
         if (cnt == 1) chk(!arr_start, "R8 start one cycle", 32'(arr_start), 0);
      end
      chk(cnt == 3, "R9 stall length", cnt, 3);
      send(3'd5, '0, '0, 16'd0, h);
      chk(arr_start && !stall, "R9 zero length", {arr_start, stall}, 2);
   endtask

   task automatic t_held_read;
      int h;
      send(3'd2, '0, 32'h0000_0001, '0, h);
      send(3'd5, '0, '0, 16'd4, h);
      send(3'd3, '0, 32'h0000_0010, '0, h);
      chk(h == 4, "R10 held cycles", h, 4);
      send(3'd4, '0, '0, '0, h);
      chk(h == 0 && rsp_valid && rsp_data == 32'h5A5A_0011, "R10 read after expiry",
          rsp_data, 32'h5A5A_0011);
      send(3'd5, '0, '0, 16'd5, h);
      send(3'd4, '0, '0, '0, h);
      chk(h == 5 && rsp_valid, "R10 read held behind run", h, 5);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_fill_and_lru();
      t_moves();
      t_exec();
      t_held_read();
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule